// File: doc/BRIEF.md
# Parallel Fixed-Point State-Space Controller Bank

This block evaluates fifteen independent single-input, single-output discrete-time controllers. All of them advance together on one sampling pulse. Each channel keeps a state vector of up to six elements and its own set of coefficients: a 6x6 transition matrix, an input column, an output row and a direct feedthrough term. On each pulse, every active channel does two things. It forms its control output from the state it held before the pulse, plus a feedthrough contribution from the present input. It then replaces that state with the transition of the old state plus the input contribution.

Three channels take satellite attitude errors and produce attitude torques. The other twelve channels take filtered test-mass states. Three of those produce drag-free forces and nine produce electrostatic suspension forces. Coefficients are written one word at a time through a small write port. A per-channel enable mask selects which channels run. The results appear one clock after the pulse, flagged by a single-cycle valid signal.

Top module: `dsc_ctrl_bank`

## Requirements
- R1: On a pulse, an enabled channel's output is sat16(rnd(C·x + D·u)). Here x is the state held before the pulse, u is the 16-bit signed input, and coefficients are signed 16-bit with 12 fraction bits. rnd(v) = (v + 2048) >> 12, arithmetic. sat16 clamps to [-32768, 32767].
- R2: On the same pulse, an enabled channel's state becomes sat24(rnd(A·x + B·u)) element by element. The new state is used from the next pulse on.
- R3: A high level on rst clears all states, outputs, coefficients and the valid flag at once, without waiting for a clock edge.
- R4: out_valid is high exactly in the cycle after a pulse cycle. Outputs change only on the edge that ends a pulse cycle.
- R5: Input lanes map to channels and outputs as follows. Channels 0–2 read att_err_i lanes 0–2 and drive att_force_o lanes 0–2. Channels 3–5 read tm_state_i lanes 0–2 and drive df_force_o lanes 0–2. Channels 6–14 read tm_state_i lanes 3–11 and drive susp_force_o lanes 0–8. Lane k occupies bits [16k+15:16k].
- R6: A channel whose chan_en bit is low at the pulse drives zero on its output and keeps its state unchanged.
- R7: Coefficient word addresses are as follows. A(r,j) is at r·6+j, B(r) at 36+r, C(i) at 42+i, D at 48. A write with cfg_chan ≥ 15 or cfg_addr ≥ 49 changes nothing.
- R8: Outputs saturate at the 16-bit limits rather than wrapping.
- R9: State elements saturate at the 24-bit signed limits rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| sample_stb | input | 1 | One-cycle sampling pulse |
| chan_en | input | 15 | Per-channel run enable |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_chan | input | 4 | Channel selected for the write |
| cfg_addr | input | 6 | Coefficient word address |
| cfg_data | input | 16 | Coefficient value, signed, 12 fraction bits |
| att_err_i | input | 48 | Three attitude error lanes |
| tm_state_i | input | 192 | Twelve test-mass state lanes |
| att_force_o | output | 48 | Three attitude torque lanes |
| df_force_o | output | 48 | Three drag-free force lanes |
| susp_force_o | output | 144 | Nine suspension force lanes |
| out_valid | output | 1 | Result-ready pulse |

## Verification
The assertions assume that sample_stb is held for exactly one cycle at a time. They also assume that chan_en is steady in the cycle the pulse is sampled. The stimulus satisfies both: every pulse is raised on one falling edge and dropped on the next, and the mask changes only together with that pulse. Coefficient writes are never issued in a pulse cycle. The expected values are therefore unambiguous, and the bench reference can reproduce the rounding and both saturation limits bit for bit. Those limits are reached on purpose in a phase that uses full-range coefficients and inputs.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
    parameter int NATT = 3;
    parameter int NTM  = 12;
    parameter int NDF  = 3;
    parameter int NSU  = 9;
    parameter int NST  = 6;
    parameter int IW   = 16;
    parameter int OW   = 16;
    parameter int CW   = 16;
    parameter int CF   = 12;
    parameter int SW   = 24;

    localparam int NCH   = NATT + NTM;
    localparam int NCO   = NST * NST + 2 * NST + 1;
    localparam int IDX_B = NST * NST;
    localparam int IDX_C = IDX_B + NST;
    localparam int IDX_D = NCO - 1;
    localparam int CHW   = $clog2(NCH + 1);
    localparam int CAW   = $clog2(NCO);
    localparam int ACW   = CW + SW + $clog2(NST + 1) + 1;

    typedef logic signed [ACW-1:0] acc_t;
    typedef logic [NST-1:0][SW-1:0] st_vec_t;
    typedef logic [NCO-1:0][CW-1:0] coef_arr_t;

    typedef struct packed {
        logic [NCH-1:0][NST-1:0][SW-1:0] x;
        logic [NCH-1:0][OW-1:0]          y;
        logic                            vld;
    } bank_st_t;

    localparam acc_t RND_HALF = acc_t'(1 << (CF - 1));
    localparam acc_t OUT_MAX  = acc_t'((1 << (OW - 1)) - 1);
    localparam acc_t OUT_MIN  = acc_t'(-(1 << (OW - 1)));
    localparam acc_t ST_MAX   = acc_t'((1 << (SW - 1)) - 1);
    localparam acc_t ST_MIN   = acc_t'(-(1 << (SW - 1)));

    function automatic acc_t mac(input logic [CW-1:0] c, input logic [SW-1:0] v);
        acc_t a;
        acc_t b;
        a = acc_t'($signed(c));
        b = acc_t'($signed(v));
        return a * b;
    endfunction

    function automatic acc_t rnd_shift(input acc_t v);
        return (v + RND_HALF) >>> CF;
    endfunction

    function automatic logic [OW-1:0] sat_out(input acc_t v);
        if (v > OUT_MAX) return OUT_MAX[OW-1:0];
        if (v < OUT_MIN) return OUT_MIN[OW-1:0];
        return v[OW-1:0];
    endfunction

    function automatic logic [SW-1:0] sat_st(input acc_t v);
        if (v > ST_MAX) return ST_MAX[SW-1:0];
        if (v < ST_MIN) return ST_MIN[SW-1:0];
        return v[SW-1:0];
    endfunction
endpackage

// File: rtl/dsc_coef_store.sv
`timescale 1ns/1ps
module dsc_coef_store
    import dsc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [CAW-1:0] addr,
    input  logic [CW-1:0]  data,
    output coef_arr_t      coef
);
    coef_arr_t coef_d, coef_q;

    always_comb begin
        coef_d = coef_q;
        if (we && (int'(addr) < NCO)) begin
            coef_d[addr] = data;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) coef_q <= '0;
        else     coef_q <= coef_d;
    end

    assign coef = coef_q;
endmodule

// File: rtl/dsc_chan_math.sv
`timescale 1ns/1ps
module dsc_chan_math
    import dsc_pkg::*;
(
    input  coef_arr_t       coef,
    input  st_vec_t         x_cur,
    input  logic [IW-1:0]   u,
    output logic [OW-1:0]   y,
    output st_vec_t         x_nxt
);
    logic [SW-1:0] u_ext;
    assign u_ext = {{(SW-IW){u[IW-1]}}, u};

    always_comb begin
        acc_t acc;
        acc = mac(coef[IDX_D], u_ext);
        for (int i = 0; i < NST; i++) begin
            acc = acc + mac(coef[IDX_C + i], x_cur[i]);
        end
        y = sat_out(rnd_shift(acc));
    end

    always_comb begin
        for (int r = 0; r < NST; r++) begin
            acc_t acc;
            acc = mac(coef[IDX_B + r], u_ext);
            for (int j = 0; j < NST; j++) begin
                acc = acc + mac(coef[r * NST + j], x_cur[j]);
            end
            x_nxt[r] = sat_st(rnd_shift(acc));
        end
    end
endmodule

// File: rtl/dsc_ctrl_bank.sv
`timescale 1ns/1ps
module dsc_ctrl_bank
    import dsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_stb,
    input  logic [NCH-1:0]       chan_en,
    input  logic                 cfg_we,
    input  logic [CHW-1:0]       cfg_chan,
    input  logic [CAW-1:0]       cfg_addr,
    input  logic [CW-1:0]        cfg_data,
    input  logic [NATT*IW-1:0]   att_err_i,
    input  logic [NTM*IW-1:0]    tm_state_i,
    output logic [NATT*OW-1:0]   att_force_o,
    output logic [NDF*OW-1:0]    df_force_o,
    output logic [NSU*OW-1:0]    susp_force_o,
    output logic                 out_valid
);
    bank_st_t      bank_d, bank_q;
    coef_arr_t     coef   [NCH];
    logic [IW-1:0] u_lane [NCH];
    logic [OW-1:0] y_calc [NCH];
    st_vec_t       x_calc [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        if (k < NATT) begin : g_att_in
            assign u_lane[k] = att_err_i[k*IW +: IW];
        end else begin : g_tm_in
            assign u_lane[k] = tm_state_i[(k-NATT)*IW +: IW];
        end

        if (k < NATT) begin : g_att_out
            assign att_force_o[k*OW +: OW] = bank_q.y[k];
        end else if (k < NATT + NDF) begin : g_df_out
            assign df_force_o[(k-NATT)*OW +: OW] = bank_q.y[k];
        end else begin : g_su_out
            assign susp_force_o[(k-NATT-NDF)*OW +: OW] = bank_q.y[k];
        end

        dsc_coef_store u_coef (
            .clk  (clk),
            .rst  (rst),
            .we   (cfg_we && (cfg_chan == CHW'(k))),
            .addr (cfg_addr),
            .data (cfg_data),
            .coef (coef[k])
        );

        dsc_chan_math u_math (
            .coef  (coef[k]),
            .x_cur (bank_q.x[k]),
            .u     (u_lane[k]),
            .y     (y_calc[k]),
            .x_nxt (x_calc[k])
        );
    end

    always_comb begin
        bank_d     = bank_q;
        bank_d.vld = sample_stb;
        if (sample_stb) begin
            for (int k = 0; k < NCH; k++) begin
                if (chan_en[k]) begin
                    bank_d.x[k] = x_calc[k];
                    bank_d.y[k] = y_calc[k];
                end else begin
                    bank_d.y[k] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assign out_valid = bank_q.vld;
endmodule

// File: rtl/dsc_ctrl_bank_chk.sv
`timescale 1ns/1ps
module dsc_ctrl_bank_chk
    import dsc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sample_stb,
    input logic [NCH-1:0]     chan_en,
    input logic [NATT*OW-1:0] att_force_o,
    input logic [NDF*OW-1:0]  df_force_o,
    input logic [NSU*OW-1:0]  susp_force_o,
    input logic               out_valid
);
    logic [NCH*OW-1:0] all_y;
    assign all_y = {susp_force_o, df_force_o, att_force_o};

    p_valid_after_stb_r4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> out_valid);

    p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> !out_valid);

    p_hold_outputs_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(all_y));

    for (genvar k = 0; k < NCH; k++) begin : g_off
        p_disabled_zero_r6: assert property (@(posedge clk) disable iff (rst)
            (sample_stb && !chan_en[k]) |=> (all_y[k*OW +: OW] == '0));
    end
endmodule

bind dsc_ctrl_bank dsc_ctrl_bank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_stb   (sample_stb),
    .chan_en      (chan_en),
    .att_force_o  (att_force_o),
    .df_force_o   (df_force_o),
    .susp_force_o (susp_force_o),
    .out_valid    (out_valid)
);

// File: tb/tb_dsc_ctrl_bank.sv
`timescale 1ns/1ps
module tb_dsc_ctrl_bank;
    import dsc_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_stb = 1'b0;
    logic [NCH-1:0]     chan_en = '0;
    logic               cfg_we = 1'b0;
    logic [CHW-1:0]     cfg_chan = '0;
    logic [CAW-1:0]     cfg_addr = '0;
    logic [CW-1:0]      cfg_data = '0;
    logic [NATT*IW-1:0] att_err_i = '0;
    logic [NTM*IW-1:0]  tm_state_i = '0;
    logic [NATT*OW-1:0] att_force_o;
    logic [NDF*OW-1:0]  df_force_o;
    logic [NSU*OW-1:0]  susp_force_o;
    logic               out_valid;

    always #2 clk = ~clk;

    dsc_ctrl_bank dut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .chan_en(chan_en),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .att_err_i(att_err_i), .tm_state_i(tm_state_i),
        .att_force_o(att_force_o), .df_force_o(df_force_o),
        .susp_force_o(susp_force_o), .out_valid(out_valid)
    );

    int     n_checks = 0;
    int     n_err = 0;
    bit     finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    longint cm   [NCH][NCO];
    longint xm   [NCH][NST];
    longint yexp [NCH];
    longint uin  [NCH];

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic longint rnd12(input longint v);
        return (v + (64'sd1 <<< (CF - 1))) >>> CF;
    endfunction

    function automatic longint satw(input longint v, input int w);
        longint mx;
        mx = (64'sd1 <<< (w - 1)) - 1;
        if (v > mx) return mx;
        if (v < -mx - 1) return -mx - 1;
        return v;
    endfunction

    function automatic longint lane_out(input int k);
        if (k < NATT) return longint'($signed(att_force_o[k*OW +: OW]));
        if (k < NATT + NDF) return longint'($signed(df_force_o[(k-NATT)*OW +: OW]));
        return longint'($signed(susp_force_o[(k-NATT-NDF)*OW +: OW]));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_rand(output logic [31:0] v);
        seed = lcg(seed);
        v = seed;
    endtask

    task automatic write_cfg(input int ch, input int addr, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = CHW'(ch); cfg_addr = CAW'(addr); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ch < NCH && addr < NCO) cm[ch][addr] = longint'($signed(d));
    endtask

    task automatic program_all(input int amag, input int omag);
        logic [31:0] r;
        for (int ch = 0; ch < NCH; ch++) begin
            for (int a = 0; a < NCO; a++) begin
                int mag;
                mag = (a < IDX_B) ? amag : omag;
                next_rand(r);
                write_cfg(ch, a, 16'(int'(r[15:0] % (2 * mag + 1)) - mag));
            end
        end
    endtask

    task automatic model_step(input logic [NCH-1:0] mask);
        longint acc;
        longint xn [NST];
        for (int k = 0; k < NCH; k++) begin
            if (mask[k]) begin
                acc = cm[k][IDX_D] * uin[k];
                for (int i = 0; i < NST; i++) acc += cm[k][IDX_C + i] * xm[k][i];
                yexp[k] = satw(rnd12(acc), OW);
                for (int r = 0; r < NST; r++) begin
                    acc = cm[k][IDX_B + r] * uin[k];
                    for (int j = 0; j < NST; j++) acc += cm[k][r * NST + j] * xm[k][j];
                    xn[r] = satw(rnd12(acc), SW);
                end
                for (int r = 0; r < NST; r++) xm[k][r] = xn[r];
            end else begin
                yexp[k] = 0;
            end
        end
    endtask

    // Drives one sample with inputs uin (lane mapping per R5) and checks R1, R2, R4, R5, R6
    task automatic do_sample(input logic [NCH-1:0] mask, input string req);
        @(negedge clk);
        for (int k = 0; k < NCH; k++) begin
            if (k < NATT) att_err_i[k*IW +: IW] = IW'(uin[k]);
            else tm_state_i[(k-NATT)*IW +: IW] = IW'(uin[k]);
        end
        chan_en = mask;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        model_step(mask);
        check(out_valid == 1'b1, "R4 valid after pulse", longint'(out_valid), 1);
        for (int k = 0; k < NCH; k++) begin
            check(lane_out(k) == yexp[k], mask[k] ? req : "R6 disabled lane zero",
                  lane_out(k), yexp[k]);
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R4 single-cycle valid", longint'(out_valid), 0);
        check(lane_out(NCH - 1) == yexp[NCH - 1], "R4 outputs held", lane_out(NCH - 1), yexp[NCH - 1]);
    endtask

    task automatic rand_inputs(input int mag);
        logic [31:0] r;
        for (int k = 0; k < NCH; k++) begin
            next_rand(r);
            uin[k] = longint'(int'(r[19:0] % (2 * mag + 1)) - mag);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < NCH; k++) begin
            yexp[k] = 0;
            uin[k] = 0;
            for (int i = 0; i < NST; i++) xm[k][i] = 0;
            for (int a = 0; a < NCO; a++) cm[k][a] = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R3: reset state
        check(out_valid == 1'b0, "R3 reset valid", longint'(out_valid), 0);
        for (int k = 0; k < NCH; k++) check(lane_out(k) == 0, "R3 reset outputs", lane_out(k), 0);
        rst = 1'b0;

        // R1 R2 R5: moderate coefficients, full enable, varied inputs
        program_all(600, 4000);
        for (int n = 0; n < 120; n++) begin
            rand_inputs((n < 40) ? 300 : 30000);
            do_sample('1, "R1,R2,R5 channel result");
        end

        // R6: enable mask sweep, single channels and patterns
        for (int b = 0; b < NCH; b++) begin
            rand_inputs(20000);
            do_sample(NCH'(1) << b, "R6 single enabled channel");
        end
        rand_inputs(20000); do_sample(15'h0000, "R6 all disabled");
        rand_inputs(20000); do_sample(15'h5555, "R6 mask 5555");
        rand_inputs(20000); do_sample(15'h2AAA, "R6 mask 2AAA");
        rand_inputs(20000); do_sample('1, "R6 state held while disabled");

        // R7: out-of-range writes change nothing
        write_cfg(NCH, 0, 16'h7FFF);
        write_cfg(0, NCO, 16'h7FFF);
        write_cfg(2, 63, 16'h8000);
        rand_inputs(20000); do_sample('1, "R7 ignored writes");
        write_cfg(4, IDX_D, 16'h1000);
        rand_inputs(20000); do_sample('1, "R7 D address write");

        // R8 R9: full-range coefficients and inputs drive saturation
        program_all(32767, 32767);
        for (int n = 0; n < 40; n++) begin
            rand_inputs(32767);
            do_sample('1, "R8,R9 saturated result");
        end
        write_cfg(1, IDX_D, 16'h7FFF);
        for (int i = 0; i < NST; i++) write_cfg(1, IDX_C + i, 16'h0000);
        uin[1] = 32767;
        do_sample('1, "R8 positive clamp");
        check(lane_out(1) == 32767, "R8 clamp value", lane_out(1), 32767);

        // R3: asynchronous reset between edges
        @(negedge clk);
        #0.5 rst = 1'b1;
        #0.5;
        check(out_valid == 1'b0, "R3 async valid", longint'(out_valid), 0);
        for (int k = 0; k < NCH; k++) check(lane_out(k) == 0, "R3 async outputs", lane_out(k), 0);
        clear_model();
        @(negedge clk);
        rst = 1'b0;
        rand_inputs(30000);
        do_sample('1, "R3 coefficients cleared");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule